// File: doc/BRIEF.md
# Three-Format Instruction Word Decoder

This block decodes the 16-bit leading word of an instruction for a small 32-bit register machine with sixteen general registers. The two most significant bits choose one of three encodings. The block then pulls out the opcode, the register indices, the 8-bit immediate or the branch offset that each encoding holds. It also produces the branch displacement in bytes, ready for the fetch unit to add.

A fetch stage presents the word with a valid strobe. One cycle later the block shows the decoded fields, a flag that says whether a 32-bit immediate word follows, and the total instruction length in bytes (2 or 6). The fetch stage uses the length to step to the next instruction. An illegal-instruction flag marks any opcode that has no defined operation. On an illegal word the extracted fields read as zero, so later stages never act on them.

Top module: `ifmt_decoder`

## Requirements
- R1: A word with bit 15 clear is format 1 (`fmt_o` = 1). Its opcode is bits 15:8, the first register index `ra_o` is bits 7:4 and the second `rb_o` is bits 3:0. `imm_o`, `off_o` and `disp_o` read zero.
- R2: A word with bits 15:14 = 10 is format 2 (`fmt_o` = 2). Its opcode is bits 13:12 (zero-extended), `ra_o` is bits 11:8 and the unsigned `imm_o` is bits 7:0. `rb_o`, `off_o` and `disp_o` read zero.
- R3: A word with bits 15:14 = 11 is format 3 (`fmt_o` = 3). Its opcode is bits 13:10 and the 10-bit offset `off_o` is bits 9:0. `disp_o` is that offset taken as signed and doubled (11 bits, two's complement). The register and immediate outputs read zero.
- R4: `ext_imm_o` is 1 and `len_o` is 6 only for the format 1 opcodes 0x01, 0x03, 0x08, 0x09, 0x0C, 0x0D, 0x1A, 0x1B, 0x1D, 0x1F, 0x20, 0x22, 0x24, 0x30, 0x36, 0x37, 0x38 and 0x39. Every other word gives `ext_imm_o` = 0 and `len_o` = 2.
- R5: `illegal_o` is 1 for these words: format 1 opcode 0x00, format 1 opcodes 0x0F to 0x18, format 1 opcodes 0x3A to 0x7F, and format 3 opcodes 0xA to 0xF. Every other word gives 0.
- R6: For an illegal word, `opcode_o`, `ra_o`, `rb_o`, `imm_o`, `off_o`, `disp_o` and `ext_imm_o` read zero and `len_o` reads 2. `fmt_o` still shows the decoded format.
- R7: All outputs are registered. A word presented with `in_valid_i` high on a rising edge appears on the outputs after that edge, and `out_valid_o` follows `in_valid_i` one cycle later. While `in_valid_i` is low, all decoded outputs hold their values.
- R8: While reset is active, and until the first valid word, every output reads zero.
- R9: All four format 2 opcodes are legal: add-immediate (0), subtract-immediate (1), read special register (2) and write special register (3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid_i | input | 1 | Instruction word strobe |
| instr_i | input | 16 | Leading instruction word (bits 15:8 hold the byte at the lower address) |
| out_valid_o | output | 1 | Decoded outputs were loaded on the last edge |
| fmt_o | output | 2 | Format code: 0 none, 1, 2, 3 |
| opcode_o | output | 8 | Opcode, zero-extended |
| ra_o | output | 4 | First register index |
| rb_o | output | 4 | Second register index |
| imm_o | output | 8 | Unsigned 8-bit immediate (format 2) |
| off_o | output | 10 | Raw branch offset (format 3) |
| disp_o | output | 11 | Signed byte displacement, offset doubled |
| ext_imm_o | output | 1 | A 32-bit immediate word follows |
| len_o | output | 3 | Instruction length in bytes (2 or 6) |
| illegal_o | output | 1 | Illegal instruction |

## Verification
Each of the 128 format 1 opcodes is presented with non-zero register nibbles. This shows whether the extension table and the legality ranges are right at every edge (0x00/0x01, 0x0E/0x0F, 0x18/0x19, 0x39/0x3A), and whether zeroing removes the register fields only on illegal words. All four format 2 opcodes are decoded with distinct register and immediate values, which shows that the bits 13:12 opcode is kept apart from the bits 11:8 register. Format 3 words cover offsets of zero, the most positive value, -1 and the most negative value, on both sides of the last legal opcode. These show sign handling in the displacement and the cut-off at opcode 9. Idle cycles with a changing input word, and back-to-back valid words, show the hold and the one-cycle timing.

// File: rtl/ifmt_pkg.sv
package ifmt_pkg;

  localparam int unsigned IW   = 16;  // instruction word width
  localparam int unsigned RW   = 4;   // register index width
  localparam int unsigned IMMW = 8;   // short immediate width
  localparam int unsigned OFFW = 10;  // branch offset width
  localparam int unsigned OPW  = 8;   // opcode output width
  localparam int unsigned LENW = 3;   // length field width
  localparam int unsigned LOWW = 12;  // low word bits carrying operands

  localparam int unsigned BASE_BYTES = 2;
  localparam int unsigned EXT_BYTES  = 4;

  localparam int unsigned F3_LAST_OP = 9;

  typedef enum logic [1:0] {
    FMT_NONE  = 2'd0,
    FMT_ONE   = 2'd1,
    FMT_TWO   = 2'd2,
    FMT_THREE = 2'd3
  } fmt_e;

  // format 1 opcodes followed by a 32-bit immediate word
  function automatic logic op_has_ext(input int unsigned op);
    case (op)
      32'h01, 32'h03, 32'h08, 32'h09, 32'h0c, 32'h0d,
      32'h1a, 32'h1b, 32'h1d, 32'h1f, 32'h20, 32'h22,
      32'h24, 32'h30, 32'h36, 32'h37, 32'h38, 32'h39: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // format 1 opcodes that name an operation
  function automatic logic op_defined(input int unsigned op);
    return ((op >= 32'h01) && (op <= 32'h0e)) ||
           ((op >= 32'h19) && (op <= 32'h39));
  endfunction

endpackage

// File: rtl/ifmt_f1_table.sv
module ifmt_f1_table
  import ifmt_pkg::*;
#(
  parameter int unsigned OP_W = OPW
) (
  input  logic [OP_W-1:0] op_i,
  output logic            ext_o,
  output logic            def_o
);

  localparam int unsigned ENTRIES = 1 << OP_W;

  logic [ENTRIES-1:0] ext_tab;
  logic [ENTRIES-1:0] def_tab;

  for (genvar k = 0; k < ENTRIES; k++) begin : g_row
    assign ext_tab[k] = op_has_ext(k);
    assign def_tab[k] = op_defined(k);
  end

  assign ext_o = ext_tab[op_i];
  assign def_o = def_tab[op_i];

endmodule

// File: rtl/ifmt_classify.sv
module ifmt_classify
  import ifmt_pkg::*;
#(
  parameter int unsigned WORD_W = IW,
  parameter int unsigned OP_W   = OPW
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic              f1_def_i,
  output logic [OP_W-1:0]   f1_op_o,
  output fmt_e              fmt_o,
  output logic [OP_W-1:0]   op_o,
  output logic              illegal_o
);

  localparam int unsigned TOP = WORD_W - 1;

  logic [3:0] f3_op;

  assign f1_op_o = word_i[TOP -: OP_W];
  assign f3_op   = word_i[TOP-2 -: 4];

  always_comb begin
    fmt_o     = FMT_NONE;
    op_o      = '0;
    illegal_o = 1'b0;
    if (!word_i[TOP]) begin
      fmt_o     = FMT_ONE;
      op_o      = f1_op_o;
      illegal_o = !f1_def_i;
    end else if (!word_i[TOP-1]) begin
      fmt_o     = FMT_TWO;
      op_o      = OP_W'(word_i[TOP-2 -: 2]);
      illegal_o = 1'b0;
    end else begin
      fmt_o     = FMT_THREE;
      op_o      = OP_W'(f3_op);
      illegal_o = (32'(f3_op) > F3_LAST_OP);
    end
  end

endmodule

// File: rtl/ifmt_fields.sv
module ifmt_fields
  import ifmt_pkg::*;
#(
  parameter int unsigned REG_W = RW,
  parameter int unsigned IMM_W = IMMW,
  parameter int unsigned OFF_W = OFFW,
  parameter int unsigned LOW_W = LOWW
) (
  input  fmt_e             fmt_i,
  input  logic [LOW_W-1:0] low_i,
  output logic [REG_W-1:0] ra_o,
  output logic [REG_W-1:0] rb_o,
  output logic [IMM_W-1:0] imm_o,
  output logic [OFF_W-1:0] off_o,
  output logic [OFF_W:0]   disp_o
);

  always_comb begin
    ra_o   = '0;
    rb_o   = '0;
    imm_o  = '0;
    off_o  = '0;
    disp_o = '0;
    case (fmt_i)
      FMT_ONE: begin
        ra_o = low_i[2*REG_W-1 -: REG_W];
        rb_o = low_i[REG_W-1:0];
      end
      FMT_TWO: begin
        ra_o  = low_i[IMM_W+REG_W-1 -: REG_W];
        imm_o = low_i[IMM_W-1:0];
      end
      FMT_THREE: begin
        off_o  = low_i[OFF_W-1:0];
        // signed halfword offset scaled to bytes; sign stays in the top bit
        disp_o = {low_i[OFF_W-1:0], 1'b0};
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ifmt_decoder.sv
module ifmt_decoder
  import ifmt_pkg::*;
#(
  parameter int unsigned WORD_W = IW,
  parameter int unsigned OP_W   = OPW,
  parameter int unsigned REG_W  = RW,
  parameter int unsigned IMM_W  = IMMW,
  parameter int unsigned OFF_W  = OFFW,
  parameter int unsigned LEN_W  = LENW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid_i,
  input  logic [WORD_W-1:0] instr_i,
  output logic              out_valid_o,
  output logic [1:0]        fmt_o,
  output logic [OP_W-1:0]   opcode_o,
  output logic [REG_W-1:0]  ra_o,
  output logic [REG_W-1:0]  rb_o,
  output logic [IMM_W-1:0]  imm_o,
  output logic [OFF_W-1:0]  off_o,
  output logic [OFF_W:0]    disp_o,
  output logic              ext_imm_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              illegal_o
);

  localparam logic [LEN_W-1:0] LEN_SHORT = LEN_W'(BASE_BYTES);
  localparam logic [LEN_W-1:0] LEN_LONG  = LEN_W'(BASE_BYTES + EXT_BYTES);
  localparam int unsigned      LOW_W     = OFF_W + 2;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  // decode stage
  logic [OP_W-1:0]  f1_op;
  logic             f1_ext, f1_def;
  fmt_e             dec_fmt;
  logic [OP_W-1:0]  dec_op;
  logic             dec_ill;
  logic [REG_W-1:0] dec_ra, dec_rb;
  logic [IMM_W-1:0] dec_imm;
  logic [OFF_W-1:0] dec_off;
  logic [OFF_W:0]   dec_disp;

  ifmt_f1_table #(.OP_W(OP_W)) u_table (
    .op_i  (f1_op),
    .ext_o (f1_ext),
    .def_o (f1_def)
  );

  ifmt_classify #(.WORD_W(WORD_W), .OP_W(OP_W)) u_class (
    .word_i    (instr_i),
    .f1_def_i  (f1_def),
    .f1_op_o   (f1_op),
    .fmt_o     (dec_fmt),
    .op_o      (dec_op),
    .illegal_o (dec_ill)
  );

  ifmt_fields #(.REG_W(REG_W), .IMM_W(IMM_W), .OFF_W(OFF_W), .LOW_W(LOW_W)) u_fields (
    .fmt_i  (dec_fmt),
    .low_i  (instr_i[LOW_W-1:0]),
    .ra_o   (dec_ra),
    .rb_o   (dec_rb),
    .imm_o  (dec_imm),
    .off_o  (dec_off),
    .disp_o (dec_disp)
  );

  // next-state values
  logic [1:0]       nx_fmt;
  logic [OP_W-1:0]  nx_op;
  logic [REG_W-1:0] nx_ra, nx_rb;
  logic [IMM_W-1:0] nx_imm;
  logic [OFF_W-1:0] nx_off;
  logic [OFF_W:0]   nx_disp;
  logic             nx_ext;
  logic [LEN_W-1:0] nx_len;

  always_comb begin
    nx_fmt  = dec_fmt;
    nx_op   = dec_op;
    nx_ra   = dec_ra;
    nx_rb   = dec_rb;
    nx_imm  = dec_imm;
    nx_off  = dec_off;
    nx_disp = dec_disp;
    nx_ext  = (dec_fmt == FMT_ONE) && f1_ext;
    if (dec_ill) begin
      nx_op   = '0;
      nx_ra   = '0;
      nx_rb   = '0;
      nx_imm  = '0;
      nx_off  = '0;
      nx_disp = '0;
      nx_ext  = 1'b0;
    end
    nx_len = nx_ext ? LEN_LONG : LEN_SHORT;
  end

  // output registers, loaded on the strobe
  logic             vld_q;
  logic [1:0]       fmt_q;
  logic [OP_W-1:0]  op_q;
  logic [REG_W-1:0] ra_q, rb_q;
  logic [IMM_W-1:0] imm_q;
  logic [OFF_W-1:0] off_q;
  logic [OFF_W:0]   disp_q;
  logic             ext_q;
  logic [LEN_W-1:0] len_q;
  logic             ill_q;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      vld_q  <= 1'b0;
      fmt_q  <= '0;
      op_q   <= '0;
      ra_q   <= '0;
      rb_q   <= '0;
      imm_q  <= '0;
      off_q  <= '0;
      disp_q <= '0;
      ext_q  <= 1'b0;
      len_q  <= '0;
      ill_q  <= 1'b0;
    end else begin
      vld_q <= in_valid_i;
      if (in_valid_i) begin
        fmt_q  <= nx_fmt;
        op_q   <= nx_op;
        ra_q   <= nx_ra;
        rb_q   <= nx_rb;
        imm_q  <= nx_imm;
        off_q  <= nx_off;
        disp_q <= nx_disp;
        ext_q  <= nx_ext;
        len_q  <= nx_len;
        ill_q  <= dec_ill;
      end
    end
  end

  assign out_valid_o = vld_q;
  assign fmt_o       = fmt_q;
  assign opcode_o    = op_q;
  assign ra_o        = ra_q;
  assign rb_o        = rb_q;
  assign imm_o       = imm_q;
  assign off_o       = off_q;
  assign disp_o      = disp_q;
  assign ext_imm_o   = ext_q;
  assign len_o       = len_q;
  assign illegal_o   = ill_q;

  // R7: the strobe shows up on out_valid_o one cycle later
  a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid_i |=> out_valid_o);

  // R7: idle cycles leave the decoded outputs unchanged
  a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_valid_i |=> ($stable(opcode_o) && $stable(ra_o) && $stable(imm_o) &&
                     $stable(disp_o) && $stable(fmt_o) && $stable(len_o)));

  // R1: a strobed word with a clear top bit decodes as format 1
  a_r1_top_bit_fmt1: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid_i && !instr_i[WORD_W-1]) |=> (fmt_o == 2'(FMT_ONE)));

  // R6: an illegal word carries no operand fields
  a_r6_illegal_zero: assert property (@(posedge clk) disable iff (!rst_q_n)
    illegal_o |-> (opcode_o == '0 && ra_o == '0 && rb_o == '0 && imm_o == '0 &&
                   disp_o == '0 && !ext_imm_o));

  // R4: only format 1 words may claim a trailing immediate
  a_r4_ext_only_fmt1: assert property (@(posedge clk) disable iff (!rst_q_n)
    ext_imm_o |-> (fmt_o == 2'(FMT_ONE) && len_o == LEN_LONG));

  // R3: format 3 carries no register index
  a_r3_fmt3_no_regs: assert property (@(posedge clk) disable iff (!rst_q_n)
    (fmt_o == 2'(FMT_THREE)) |-> (ra_o == '0 && rb_o == '0 && imm_o == '0));

  // R9: format 2 never flags illegal
  a_r9_fmt2_legal: assert property (@(posedge clk) disable iff (!rst_q_n)
    (fmt_o == 2'(FMT_TWO)) |-> !illegal_o);

endmodule

// File: tb/ifmt_decoder_test.sv
module ifmt_decoder_test;

  logic        clk;
  logic        rst_n;
  logic        in_valid_i;
  logic [15:0] instr_i;
  logic        out_valid_o;
  logic [1:0]  fmt_o;
  logic [7:0]  opcode_o;
  logic [3:0]  ra_o, rb_o;
  logic [7:0]  imm_o;
  logic [9:0]  off_o;
  logic [10:0] disp_o;
  logic        ext_imm_o;
  logic [2:0]  len_o;
  logic        illegal_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  ifmt_decoder uut (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .instr_i(instr_i),
    .out_valid_o(out_valid_o), .fmt_o(fmt_o), .opcode_o(opcode_o),
    .ra_o(ra_o), .rb_o(rb_o), .imm_o(imm_o), .off_o(off_o), .disp_o(disp_o),
    .ext_imm_o(ext_imm_o), .len_o(len_o), .illegal_o(illegal_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // valid, fmt, opcode, ra, rb, imm, off, disp, ext, len, illegal
  function automatic logic [52:0] actual_vec();
    return {out_valid_o, fmt_o, opcode_o, ra_o, rb_o, imm_o, off_o, disp_o,
            ext_imm_o, len_o, illegal_o};
  endfunction

  function automatic logic [52:0] expect_vec(input logic [15:0] w);
    logic [1:0] f; logic [7:0] op; logic [3:0] a, b; logic [7:0] im;
    logic [9:0] of; logic [10:0] ds; logic ex, il;
    f = 0; op = 0; a = 0; b = 0; im = 0; of = 0; ds = 0; ex = 0; il = 0;
    if (!w[15]) begin                       // R1
      f = 1; op = w[15:8]; a = w[7:4]; b = w[3:0];
      il = !((op >= 8'h01 && op <= 8'h0e) || (op >= 8'h19 && op <= 8'h39));
      ex = op inside {8'h01, 8'h03, 8'h08, 8'h09, 8'h0c, 8'h0d, 8'h1a, 8'h1b,
                      8'h1d, 8'h1f, 8'h20, 8'h22, 8'h24, 8'h30, 8'h36, 8'h37,
                      8'h38, 8'h39};        // R4
    end else if (!w[14]) begin              // R2
      f = 2; op = {6'd0, w[13:12]}; a = w[11:8]; im = w[7:0];
    end else begin                          // R3
      f = 3; op = {4'd0, w[13:10]}; of = w[9:0];
      ds = 11'($signed(w[9:0]) * 2);
      il = (w[13:10] > 4'd9);               // R5
    end
    if (il) begin                           // R6
      op = 0; a = 0; b = 0; im = 0; of = 0; ds = 0; ex = 0;
    end
    return {1'b1, f, op, a, b, im, of, ds, ex, (ex ? 3'd6 : 3'd2), il};
  endfunction

  task automatic check_vec(input string req, input logic [52:0] act,
                           input logic [52:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic decode_one(input logic [15:0] w, input string req);
    @(negedge clk);
    in_valid_i = 1'b1;
    instr_i    = w;
    @(negedge clk);
    in_valid_i = 1'b0;
    check_vec(req, actual_vec(), expect_vec(w));
  endtask

  // R8: reset state
  task automatic t_reset();
    rst_n = 1'b0; in_valid_i = 1'b0; instr_i = 16'h0000;
    repeat (3) @(negedge clk);
    check_vec("R8", actual_vec(), 53'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_vec("R8", actual_vec(), 53'd0);
  endtask

  // R1: register fields of format 1
  task automatic t_fmt1_basic();
    decode_one(16'h0512, "R1");
    decode_one(16'h26fe, "R1");
    decode_one(16'h01c0, "R4");
  endtask

  // R4, R5: every format 1 opcode
  task automatic t_fmt1_sweep();
    for (int op = 0; op < 128; op++) begin
      decode_one({op[7:0], 8'ha5}, (op == 0 || (op > 8'h0e && op < 8'h19) ||
                  op > 8'h39) ? "R5" : "R4");
    end
  endtask

  // R2, R9: format 2 opcodes
  task automatic t_fmt2();
    decode_one(16'h8a7f, "R2");
    decode_one(16'h9355, "R9");
    decode_one(16'ha2c8, "R9");
    decode_one(16'hbf01, "R9");
  endtask

  // R3, R5: format 3 offsets and opcode limit
  task automatic t_fmt3();
    decode_one(16'hc000 | (16'd0 << 10) | 16'h000, "R3");
    decode_one(16'hc000 | (16'd1 << 10) | 16'h1ff, "R3");
    decode_one(16'hc000 | (16'd5 << 10) | 16'h3ff, "R3");
    decode_one(16'hc000 | (16'd9 << 10) | 16'h200, "R3");
    decode_one(16'hc000 | (16'd10 << 10) | 16'h155, "R5");
    decode_one(16'hc000 | (16'd15 << 10) | 16'h3ff, "R5");
  endtask

  // R6: illegal words zero their fields at the ports
  task automatic t_illegal_zero();
    decode_one(16'h00ff, "R6");
    checks++;
    if (opcode_o !== 8'd0 || ra_o !== 4'd0 || rb_o !== 4'd0 || len_o !== 3'd2 ||
        fmt_o !== 2'd1 || illegal_o !== 1'b1) begin
      errors++;
      $display("FAIL R6 actual op=%h ra=%h rb=%h len=%0d fmt=%0d ill=%b expected 0 0 0 2 1 1",
               opcode_o, ra_o, rb_o, len_o, fmt_o, illegal_o);
    end
    decode_one(16'h7f3c, "R6");
  endtask

  // R7: hold while idle, back-to-back words
  task automatic t_timing();
    logic [52:0] held;
    decode_one(16'h0934, "R7");
    held = actual_vec();
    for (int k = 0; k < 3; k++) begin
      instr_i = 16'hc3ff ^ 16'(k);
      @(negedge clk);
      check_vec("R7", actual_vec(), {1'b0, held[51:0]});
    end
    @(negedge clk);
    in_valid_i = 1'b1; instr_i = 16'h8123;
    @(negedge clk);
    instr_i = 16'h2045;
    check_vec("R7", actual_vec(), expect_vec(16'h8123));
    @(negedge clk);
    in_valid_i = 1'b0;
    check_vec("R7", actual_vec(), expect_vec(16'h2045));
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fmt1_basic();
    t_fmt1_sweep();
    t_fmt2();
    t_fmt3();
    t_illegal_zero();
    t_timing();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule